// File: doc/BRIEF.md
# Circular-Buffer Post-Modify Address Unit

This unit produces data-memory addresses for a signal processor. It holds four general pointers into a 512-word data RAM. Each pointer has its own base and length registers, which describe a circular buffer. Two lanes can each pick any pointer in the same cycle, so one instruction can fetch two operands. Each lane drives the chosen pointer's current value out as the address, together with a read/write flag. It then updates that pointer with one of four modify actions. If the length is nonzero, a result that leaves the buffer is folded back inside it. The buffer may have any length and any base, not only a power of two.

A fifth pointer, 16 bits wide, addresses coefficient tables in program space. It can be loaded directly, and when used it steps forward by one with plain 16-bit rollover. Instruction decode and the memories themselves sit outside this block.

Top module: `circ_agu`

## Requirements
- R1: Synchronous reset clears all pointers, bases, lengths and the table pointer to zero. The cycle after reset, every valid output is low.
- R2: When a lane is enabled, then one clock later: its valid output is high, its address equals the selected pointer's value before the update, and its write flag equals the lane's request.
- R3: The modify code acts on the selected pointer: 0 leaves it unchanged, 1 adds one, 2 subtracts one, 3 adds the lane's signed 8-bit step.
- R4: With a nonzero length L, a result at or above base+L has L subtracted from it. This works for any L, including values that are not a power of two.
- R5: With a nonzero length L, a result below base has L added to it.
- R6: A length of zero gives linear addressing, wrapping only at the 512-word address space (511+1 gives 0, 0-1 gives 511).
- R7: The two lanes can use different pointers in the same cycle without affecting each other.
- R8: When both lanes select the same pointer, both output the same address, and only lane 0's modification is kept.
- R9: A configuration write sets one register, chosen by field: 0 for the pointer, 1 for the base, 2 for the length. A pointer write overrides a lane update to that pointer in the same cycle.
- R10: When the table-read enable is high, the current 16-bit table pointer is output one cycle later with its valid flag, and the pointer steps by one, rolling from 0xFFFF to 0x0000. A table load sets the pointer and takes precedence over the step.
- R11: A disabled lane does not change any pointer, whatever its modify code, and its valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | 2 | Per-lane request |
| lane_sel | input | 2x2 | Pointer chosen by each lane |
| lane_mod | input | 2x2 | Modify code for each lane |
| lane_step | input | 2x8 | Signed step for each lane |
| lane_wr | input | 2 | Write (1) or read (0) for each lane |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Pointer set being configured |
| cfg_field | input | 2 | 0 pointer, 1 base, 2 length |
| cfg_data | input | 9 | Configuration value |
| rom_en | input | 1 | Table read request |
| rom_load | input | 1 | Table pointer load |
| rom_load_val | input | 16 | Table pointer load value |
| lane_addr | output | 2x9 | Registered RAM address for each lane |
| lane_we | output | 2 | Registered write flag for each lane |
| lane_vld | output | 2 | Registered valid for each lane |
| rom_addr | output | 16 | Registered table address |
| rom_vld | output | 1 | Registered table valid |

## Verification
Runs of single steps up and down show whether the hold, increment, decrement and signed-step codes are decoded correctly. A buffer of length five is walked past its top and below its base, and a length-seven buffer is hit with steps of -4 and +3. Together these separate a correct fold from a power-of-two mask or a missing fold. A length-zero pointer is pushed across 511/0 in both directions to check the linear case. Same-pointer and different-pointer dual-lane cycles, a configuration write that collides with a lane update, and a 16-bit table rollover decide the priority rules.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
  typedef enum logic [1:0] {
    MOD_HOLD = 2'd0,
    MOD_INC  = 2'd1,
    MOD_DEC  = 2'd2,
    MOD_STEP = 2'd3
  } mod_e;

  typedef enum logic [1:0] {
    CFG_PTR  = 2'd0,
    CFG_BASE = 2'd1,
    CFG_LEN  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_e;
endpackage

// File: rtl/circ_agu_wrap.sv
module circ_agu_wrap import circ_agu_pkg::*; #(
  parameter int AW     = 9,
  parameter int STEP_W = 8
) (
  input  logic [AW-1:0]     cur,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     len,
  input  mod_e              mode,
  input  logic [STEP_W-1:0] step,
  output logic [AW-1:0]     nxt
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] delta, sum, lo, hi, fold;

  always_comb begin
    unique case (mode)
      MOD_INC:  delta = EW'(1);
      MOD_DEC:  delta = -EW'(1);
      MOD_STEP: delta = {{(EW-STEP_W){step[STEP_W-1]}}, step};
      default:  delta = '0;
    endcase
    sum = $signed({2'b00, cur}) + delta;
    lo  = $signed({2'b00, base});
    hi  = lo + $signed({2'b00, len});
    if (len == '0)     fold = sum;
    else if (sum >= hi) fold = sum - $signed({2'b00, len});
    else if (sum < lo)  fold = sum + $signed({2'b00, len});
    else                fold = sum;
    nxt = fold[AW-1:0];
  end
endmodule

// File: rtl/circ_agu_rom.sv
module circ_agu_rom #(
  parameter int ROM_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              load,
  input  logic [ROM_AW-1:0] load_val,
  output logic [ROM_AW-1:0] addr_q,
  output logic              vld_q,
  output logic [ROM_AW-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) addr_q <= ptr_q;
      if (load)       ptr_q <= load_val;
      else if (rd_en) ptr_q <= ptr_q + ROM_AW'(1);
    end
  end
endmodule

// File: rtl/circ_agu.sv
module circ_agu import circ_agu_pkg::*; #(
  parameter int NPTR   = 4,
  parameter int NLANE  = 2,
  parameter int RAM_AW = 9,
  parameter int STEP_W = 8,
  parameter int ROM_AW = 16,
  localparam int SEL_W = $clog2(NPTR)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NLANE-1:0]              lane_en,
  input  logic [NLANE-1:0][SEL_W-1:0]   lane_sel,
  input  logic [NLANE-1:0][1:0]         lane_mod,
  input  logic [NLANE-1:0][STEP_W-1:0]  lane_step,
  input  logic [NLANE-1:0]              lane_wr,
  input  logic                          cfg_we,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [1:0]                    cfg_field,
  input  logic [RAM_AW-1:0]             cfg_data,
  input  logic                          rom_en,
  input  logic                          rom_load,
  input  logic [ROM_AW-1:0]             rom_load_val,
  output logic [NLANE-1:0][RAM_AW-1:0]  lane_addr,
  output logic [NLANE-1:0]              lane_we,
  output logic [NLANE-1:0]              lane_vld,
  output logic [ROM_AW-1:0]             rom_addr,
  output logic                          rom_vld
);
  logic [RAM_AW-1:0] ptr_q  [NPTR];
  logic [RAM_AW-1:0] base_q [NPTR];
  logic [RAM_AW-1:0] len_q  [NPTR];
  logic [NLANE-1:0][RAM_AW-1:0] lane_nxt;
  logic [ROM_AW-1:0] rom_ptr;

  // Per-lane next-value computation and registered outputs
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    circ_agu_wrap #(.AW(RAM_AW), .STEP_W(STEP_W)) u_wrap (
      .cur  (ptr_q[lane_sel[l]]),
      .base (base_q[lane_sel[l]]),
      .len  (len_q[lane_sel[l]]),
      .mode (mod_e'(lane_mod[l])),
      .step (lane_step[l]),
      .nxt  (lane_nxt[l])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_addr[l] <= '0;
        lane_we[l]   <= 1'b0;
        lane_vld[l]  <= 1'b0;
      end else begin
        lane_vld[l] <= lane_en[l];
        if (lane_en[l]) begin
          lane_addr[l] <= ptr_q[lane_sel[l]];
          lane_we[l]   <= lane_wr[l];
        end
      end
    end
  end

  // Pointer register sets; the lowest-numbered lane wins on a shared pointer
  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    logic              hit;
    logic [RAM_AW-1:0] upd;
    logic              cfg_hit;

    always_comb begin
      hit = 1'b0;
      upd = ptr_q[p];
      for (int l = NLANE - 1; l >= 0; l--) begin
        if (lane_en[l] && lane_sel[l] == SEL_W'(p)) begin
          hit = 1'b1;
          upd = lane_nxt[l];
        end
      end
      cfg_hit = cfg_we && (cfg_sel == SEL_W'(p));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[p]  <= '0;
        base_q[p] <= '0;
        len_q[p]  <= '0;
      end else begin
        if (cfg_hit && cfg_field == CFG_PTR) ptr_q[p] <= cfg_data;
        else if (hit)                        ptr_q[p] <= upd;
        if (cfg_hit && cfg_field == CFG_BASE) base_q[p] <= cfg_data;
        if (cfg_hit && cfg_field == CFG_LEN)  len_q[p]  <= cfg_data;
      end
    end
  end

  circ_agu_rom #(.ROM_AW(ROM_AW)) u_rom (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rom_en),
    .load     (rom_load),
    .load_val (rom_load_val),
    .addr_q   (rom_addr),
    .vld_q    (rom_vld),
    .ptr_q    (rom_ptr)
  );
endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk #(
  parameter int NPTR   = 4,
  parameter int NLANE  = 2,
  parameter int RAM_AW = 9,
  parameter int ROM_AW = 16,
  localparam int SEL_W = $clog2(NPTR)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NLANE-1:0]              lane_en,
  input logic [NLANE-1:0][SEL_W-1:0]   lane_sel,
  input logic [NLANE-1:0][1:0]         lane_mod,
  input logic [NLANE-1:0]              lane_wr,
  input logic                          cfg_we,
  input logic [SEL_W-1:0]              cfg_sel,
  input logic [1:0]                    cfg_field,
  input logic [RAM_AW-1:0]             cfg_data,
  input logic                          rom_en,
  input logic                          rom_load,
  input logic [ROM_AW-1:0]             rom_load_val,
  input logic [NLANE-1:0][RAM_AW-1:0]  lane_addr,
  input logic [NLANE-1:0]              lane_we,
  input logic [NLANE-1:0]              lane_vld,
  input logic                          rom_vld,
  input logic [RAM_AW-1:0]             ptr_q  [NPTR],
  input logic [RAM_AW-1:0]             base_q [NPTR],
  input logic [RAM_AW-1:0]             len_q  [NPTR],
  input logic [ROM_AW-1:0]             rom_ptr
);
  logic stepping;
  logic [NPTR-1:0] inwin, touched;

  always_comb begin
    stepping = 1'b0;
    for (int l = 0; l < NLANE; l++)
      if (lane_en[l] && lane_mod[l] == 2'd3) stepping = 1'b1;
    for (int p = 0; p < NPTR; p++) begin
      inwin[p] = ({1'b0, ptr_q[p]} >= {1'b0, base_q[p]}) &&
                 ({1'b0, ptr_q[p]} < ({1'b0, base_q[p]} + {1'b0, len_q[p]}));
      touched[p] = 1'b0;
      for (int l = 0; l < NLANE; l++)
        if (lane_en[l] && lane_sel[l] == SEL_W'(p)) touched[p] = 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (lane_vld == '0 && !rom_vld));

  for (genvar l = 0; l < NLANE; l++) begin : g_lane_chk
    assert_lane_valid_R2: assert property (@(posedge clk) disable iff (rst)
      lane_en[l] |=> (lane_vld[l] && lane_we[l] == $past(lane_wr[l])));
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      !lane_en[l] |=> !lane_vld[l]);
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr_chk
    // R4 and R5: unit steps never leave a nonzero-length window
    assert_ptr_in_window_R4: assert property (@(posedge clk) disable iff (rst)
      (inwin[p] && len_q[p] != '0 && !cfg_we && !stepping) |=> inwin[p]);
    assert_cfg_ptr_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_field == 2'd0 && cfg_sel == SEL_W'(p)) |=> ptr_q[p] == $past(cfg_data));
    assert_untouched_stable_R11: assert property (@(posedge clk) disable iff (rst)
      (!touched[p] && !cfg_we) |=> $stable(ptr_q[p]));
  end

  if (NLANE >= 2) begin : g_pair_chk
    assert_shared_ptr_same_addr_R8: assert property (@(posedge clk) disable iff (rst)
      (lane_en[0] && lane_en[1] && lane_sel[0] == lane_sel[1]) |=> lane_addr[0] == lane_addr[1]);
  end

  assert_rom_inc_R10: assert property (@(posedge clk) disable iff (rst)
    (rom_en && !rom_load) |=> rom_ptr == $past(rom_ptr) + ROM_AW'(1));
  assert_rom_load_R10: assert property (@(posedge clk) disable iff (rst)
    rom_load |=> rom_ptr == $past(rom_load_val));
endmodule

bind circ_agu circ_agu_chk #(
  .NPTR(NPTR), .NLANE(NLANE), .RAM_AW(RAM_AW), .ROM_AW(ROM_AW)
) u_chk (.*);

// File: tb/circ_agu_bench.sv
module circ_agu_bench;
  localparam int NLANE = 2;
  localparam int AW    = 9;
  localparam int SW    = 8;
  localparam int RW    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NLANE-1:0]           lane_en = '0;
  logic [NLANE-1:0][1:0]      lane_sel = '0;
  logic [NLANE-1:0][1:0]      lane_mod = '0;
  logic [NLANE-1:0][SW-1:0]   lane_step = '0;
  logic [NLANE-1:0]           lane_wr = '0;
  logic                       cfg_we = 1'b0;
  logic [1:0]                 cfg_sel = '0;
  logic [1:0]                 cfg_field = 2'd3;
  logic [AW-1:0]              cfg_data = '0;
  logic                       rom_en = 1'b0;
  logic                       rom_load = 1'b0;
  logic [RW-1:0]              rom_load_val = '0;
  logic [NLANE-1:0][AW-1:0]   lane_addr;
  logic [NLANE-1:0]           lane_we;
  logic [NLANE-1:0]           lane_vld;
  logic [RW-1:0]              rom_addr;
  logic                       rom_vld;

  always #5 clk = ~clk;

  circ_agu u_circ_agu (
    .clk(clk), .rst(rst),
    .lane_en(lane_en), .lane_sel(lane_sel), .lane_mod(lane_mod),
    .lane_step(lane_step), .lane_wr(lane_wr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .rom_en(rom_en), .rom_load(rom_load), .rom_load_val(rom_load_val),
    .lane_addr(lane_addr), .lane_we(lane_we), .lane_vld(lane_vld),
    .rom_addr(rom_addr), .rom_vld(rom_vld)
  );

  typedef struct {
    string tag;
    int    a0, a1, ra;
    bit    v0, v1, w0, w1, rv;
  } item_t;

  item_t q[$];
  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference state built from the requirements
  int mp[4], mb[4], ml[4];
  int mrom = 0;
  int la0 = 0, la1 = 0, lw0 = 0, lw1 = 0, lra = 0;

  function automatic int mnext(int cur, int b, int l, int md, int st);
    int s;
    s = cur + ((md == 1) ? 1 : (md == 2) ? -1 : (md == 3) ? st : 0);
    if (l != 0) begin
      if (s >= b + l)  s = s - l;
      else if (s < b)  s = s + l;
    end
    return ((s % 512) + 512) % 512;
  endfunction

  task automatic core(string tag, int e0, int s0, int m0, int st0, int w0,
                      int e1, int s1, int m1, int st1, int w1,
                      int re, int rl, int rv, int cw, int cs, int cf, int cd);
    item_t it;
    int n0, n1;
    @(negedge clk);
    lane_en      = {e1[0], e0[0]};
    lane_sel[0]  = s0[1:0];  lane_sel[1]  = s1[1:0];
    lane_mod[0]  = m0[1:0];  lane_mod[1]  = m1[1:0];
    lane_step[0] = SW'(st0); lane_step[1] = SW'(st1);
    lane_wr      = {w1[0], w0[0]};
    rom_en = re[0]; rom_load = rl[0]; rom_load_val = RW'(rv);
    cfg_we = cw[0]; cfg_sel = cs[1:0]; cfg_field = cf[1:0]; cfg_data = AW'(cd);
    it.tag = tag;
    it.v0 = e0[0]; it.a0 = e0 != 0 ? mp[s0] : la0; it.w0 = e0 != 0 ? w0[0] : lw0[0];
    it.v1 = e1[0]; it.a1 = e1 != 0 ? mp[s1] : la1; it.w1 = e1 != 0 ? w1[0] : lw1[0];
    it.rv = re[0]; it.ra = re != 0 ? mrom : lra;
    n0 = mnext(mp[s0], mb[s0], ml[s0], m0, st0);
    n1 = mnext(mp[s1], mb[s1], ml[s1], m1, st1);
    la0 = it.a0; lw0 = it.w0; la1 = it.a1; lw1 = it.w1; lra = it.ra;
    if (e1 != 0) mp[s1] = n1;
    if (e0 != 0) mp[s0] = n0;
    if (cw != 0) begin
      if (cf == 0) mp[cs] = cd;
      else if (cf == 1) mb[cs] = cd;
      else if (cf == 2) ml[cs] = cd;
    end
    if (rl != 0) mrom = rv;
    else if (re != 0) mrom = (mrom + 1) & 16'hFFFF;
    @(posedge clk);
    #1 q.push_back(it);
  endtask

  task automatic idle(string tag);
    core(tag, 0,0,0,0,0, 0,0,0,0,0, 0,0,0, 0,0,3,0);
  endtask
  task automatic cfg(string tag, int s, int f, int d);
    core(tag, 0,0,0,0,0, 0,0,0,0,0, 0,0,0, 1,s,f,d);
  endtask
  task automatic ln0(string tag, int s, int m, int st, int w);
    core(tag, 1,s,m,st,w, 0,0,0,0,0, 0,0,0, 0,0,3,0);
  endtask
  task automatic ln2(string tag, int s0, int m0, int st0, int w0, int s1, int m1, int st1, int w1);
    core(tag, 1,s0,m0,st0,w0, 1,s1,m1,st1,w1, 0,0,0, 0,0,3,0);
  endtask
  task automatic rom(string tag, int en, int ld, int v);
    core(tag, 0,0,0,0,0, 0,0,0,0,0, en,ld,v, 0,0,3,0);
  endtask

  // Monitor: compares each expected item one clock after it was issued
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      total++;
      if (lane_vld[0] !== e.v0 || lane_addr[0] !== AW'(e.a0) || lane_we[0] !== e.w0 ||
          lane_vld[1] !== e.v1 || lane_addr[1] !== AW'(e.a1) || lane_we[1] !== e.w1 ||
          rom_vld !== e.rv || rom_addr !== RW'(e.ra)) begin
        fails++;
        $display("FAIL %s: got v=%b%b a0=%0d a1=%0d we=%b%b rv=%b ra=%h exp v=%b%b a0=%0d a1=%0d we=%b%b rv=%b ra=%h",
                 e.tag, lane_vld[1], lane_vld[0], lane_addr[0], lane_addr[1], lane_we[1], lane_we[0],
                 rom_vld, rom_addr, e.v1, e.v0, e.a0, e.a1, e.w1, e.w0, e.rv, e.ra[15:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mp[i] = 0; mb[i] = 0; ml[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle("R1 reset state");
    // R9 configuration of all pointer sets
    cfg("R9 ptr0", 0, 0, 10);
    cfg("R9 ptr1", 1, 0, 200);
    cfg("R9 base2", 2, 1, 100);
    cfg("R9 len2", 2, 2, 5);
    cfg("R9 ptr2", 2, 0, 100);
    cfg("R9 base3", 3, 1, 300);
    cfg("R9 len3", 3, 2, 7);
    cfg("R9 ptr3", 3, 0, 302);
    // R2 / R3 modify codes
    ln0("R2 R3 inc write", 0, 1, 0, 1);
    ln0("R3 dec", 0, 2, 0, 0);
    ln0("R3 hold", 0, 0, 0, 1);
    ln0("R3 step +5", 0, 3, 5, 0);
    ln0("R3 step -3", 0, 3, -3, 0);
    ln0("R3 hold readback", 0, 0, 0, 0);
    // R4 upper wrap on length 5
    for (int k = 0; k < 6; k++) ln0("R4 inc through top", 2, 1, 0, 0);
    // R5 lower wrap
    for (int k = 0; k < 3; k++) ln0("R5 dec through base", 2, 2, 0, 1);
    ln0("R5 step -4 below base", 3, 3, -4, 0);
    ln0("R4 step +3 past top", 3, 3, 3, 0);
    ln0("R4 R5 readback", 3, 0, 0, 0);
    // R6 linear addressing
    cfg("R6 ptr0 510", 0, 0, 510);
    ln0("R6 inc", 0, 1, 0, 0);
    ln0("R6 inc past 511", 0, 1, 0, 0);
    ln0("R6 dec below 0", 0, 2, 0, 0);
    ln0("R6 readback", 0, 0, 0, 0);
    // R7 independent lanes
    ln2("R7 dual lanes", 1, 1, 0, 0, 3, 2, 0, 1);
    ln2("R7 dual readback", 1, 0, 0, 1, 3, 0, 0, 0);
    // R8 shared pointer
    ln2("R8 shared pointer", 1, 1, 0, 0, 1, 3, 20, 1);
    ln0("R8 lane0 update kept", 1, 0, 0, 0);
    // R9 collision with lane update
    core("R9 cfg beats lane", 1,1,1,0,0, 0,0,0,0,0, 0,0,0, 1,1,0,50);
    ln0("R9 readback", 1, 0, 0, 0);
    // R11 disabled lane with active modify code
    core("R11 disabled lane", 0,0,1,0,1, 0,2,3,7,1, 0,0,0, 0,0,3,0);
    ln2("R11 pointers unchanged", 0, 0, 0, 0, 2, 0, 0, 0);
    // R10 table pointer
    rom("R10 load", 0, 1, 16'hFFFE);
    rom("R10 read FFFE", 1, 0, 0);
    rom("R10 read FFFF", 1, 0, 0);
    rom("R10 read rollover", 1, 0, 0);
    rom("R10 load beats step", 1, 1, 16'h1234);
    rom("R10 read loaded", 1, 0, 0);
    idle("R1 R11 idle after traffic");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule